// File: doc/BRIEF.md
# I2C Target Controller with Register Interface

This block is a bus target (slave) controller for a two-wire serial bus. It watches the clock and data lines through two-flop synchronizers, finds START and STOP conditions, and compares the first byte of each transfer against a programmable 7-bit own address. A match is acknowledged. The block then moves one byte at a time between the bus and a single 8-bit data register.

Software services every byte. After a byte arrives, or when the controller asks for one, the block holds the clock line low until software reads or writes the data register. A received byte is acknowledged only after software has read it. A small interrupt unit has three sources: data, START and STOP. Each source has a raw bit, a mask bit, a masked bit and a write-one-to-clear bit, and one interrupt line is driven from them.

The host side is a word register port with single-cycle read and write strobes and combinational read data. Both bus lines are driven as open-drain low-enables.

Top module: `i2ct_target`

## Requirements
- R1: After reset every readable register reads zero, neither bus line is pulled low and `irq` is low.
- R2: An address byte whose upper seven bits equal own-address bits [6:0] at offset 0x00 is acknowledged. Bit 0 of that byte selects the direction, 1 meaning the target sends. After an address byte that does not match, the block pulls neither line for the rest of the transfer and raises no request.
- R3: While control bit 0 (device active, written at offset 0x04) is 0, the block pulls neither line, acknowledges nothing and sets no raw interrupt bit.
- R4: A received byte sets status bit 0 (read at offset 0x04) and is returned in bits [7:0] of offset 0x08. SCL is held low until offset 0x08 is read. That read clears bit 0, and the byte is then acknowledged.
- R5: Status bit 2 is 1 only for the first data byte after a matching address, is 0 for later bytes of the same transfer, and clears on the data read.
- R6: When addressed for a send, status bit 1 is set and SCL is held low until offset 0x08 is written. The byte written is then shifted out most significant bit first. A controller ACK raises the next request. Status bits 0 and 1 are never both set.
- R7: After a controller NACK the block releases both lines and raises no further send request before the next START.
- R8: A START or STOP abandons any partial byte without handing it to software. A repeated START begins a fresh address phase.
- R9: Raw interrupt bits at offset 0x10 are set by data requests (bit 0), START (bit 1) and STOP (bit 2). Offset 0x14 reads raw AND mask (mask at offset 0x0C). `irq` is high whenever any masked bit is set.
- R10: Writing 1 to a bit at offset 0x18 clears that raw bit, and writing 0 leaves it unchanged. A set event in the same cycle wins. Offset 0x18 reads zero.
- R11: Reading offset 0x04 returns status, not the control bit just written. Own address reads back in bits [6:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rd | input | 1 | Read strobe, one cycle (read side effects) |
| reg_wdata | input | BUS_W | Write data |
| reg_rdata | output | BUS_W | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request, OR of masked bits |
| scl_i | input | 1 | Clock line level |
| sda_i | input | 1 | Data line level |
| scl_oe | output | 1 | Pull clock line low when 1 |
| sda_oe | output | 1 | Pull data line low when 1 |

## Verification
The hardest case to reach from the ports is a START arriving inside a partly shifted byte. A real controller cannot cause this while the target is stretching the clock. The bench therefore clocks four data bits after a matching write address and then issues a repeated START with a read address. It then checks that no byte reaches software and that the new transfer completes. Clock stretching is shown by letting the bus model try to release SCL while software stays silent, and observing that the line remains low for many cycles until the data register is touched.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
   localparam int BYTE_BITS = 8;
   localparam int ADR_BITS  = 7;
   localparam int IRQ_N     = 3;
   localparam int IRQ_DATA  = 0;
   localparam int IRQ_START = 1;
   localparam int IRQ_STOP  = 2;

   localparam int OFS_OWN  = 'h00;
   localparam int OFS_CTL  = 'h04;
   localparam int OFS_DATA = 'h08;
   localparam int OFS_MASK = 'h0C;
   localparam int OFS_RAW  = 'h10;
   localparam int OFS_MIS  = 'h14;
   localparam int OFS_CLR  = 'h18;

   typedef enum logic [3:0] {
      ST_IDLE, ST_ADDR, ST_AACK, ST_RXB, ST_RXW, ST_RXACK,
      ST_TXW, ST_TXB, ST_TXACK, ST_SKIP
   } eng_st_t;
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
   parameter int WIDTH = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2ct_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '1;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
   import i2ct_pkg::*;
#(
   parameter int BYTE_W = BYTE_BITS,
   parameter int ADR_W  = ADR_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic [ADR_W-1:0]  own_addr,
   input  logic              scl_s,
   input  logic              sda_s,
   input  logic              data_rd,
   input  logic              data_wr,
   input  logic [BYTE_W-1:0] tx_byte,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              rreq,
   output logic              treq,
   output logic              fbr,
   output logic [IRQ_N-1:0]  ev,
   output logic              scl_oe,
   output logic              sda_oe
);
   localparam int CNT_W = $clog2(BYTE_W + 1);

   generate
      if (ADR_W != BYTE_W - 1) begin : g_bad_width
         $error("i2ct_engine: address must fill a byte less the direction bit");
      end
   endgenerate

   eng_st_t           st;
   logic [BYTE_W-1:0] sh;
   logic [CNT_W-1:0]  cnt;
   logic              scl_q, sda_q, rw, first, ack_seen, hold, sda_drv;

   wire scl_rise = scl_s && !scl_q;
   wire scl_fall = !scl_s && scl_q;
   wire start_c  = scl_s && scl_q && sda_q && !sda_s;
   wire stop_c   = scl_s && scl_q && !sda_q && sda_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE; sh <= '0; cnt <= '0; rx_byte <= '0;
         scl_q <= 1'b1; sda_q <= 1'b1;
         rw <= 1'b0; first <= 1'b0; ack_seen <= 1'b0; hold <= 1'b0;
         sda_drv <= 1'b0; rreq <= 1'b0; treq <= 1'b0; fbr <= 1'b0; ev <= '0;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
         ev    <= '0;
         hold  <= 1'b0;
         if (!active) begin
            st <= ST_IDLE; rreq <= 1'b0; treq <= 1'b0; fbr <= 1'b0; sda_drv <= 1'b0;
         end else if (start_c || stop_c) begin
            st <= start_c ? ST_ADDR : ST_IDLE;
            cnt <= '0; rreq <= 1'b0; treq <= 1'b0; fbr <= 1'b0; sda_drv <= 1'b0;
            ev[start_c ? IRQ_START : IRQ_STOP] <= 1'b1;
         end else begin
            unique case (st)
               ST_ADDR: begin
                  if (scl_rise) begin
                     sh  <= {sh[BYTE_W-2:0], sda_s};
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall && cnt == CNT_W'(BYTE_W)) begin
                     if (sh[BYTE_W-1:1] == own_addr) begin
                        rw <= sh[0]; sda_drv <= 1'b1; st <= ST_AACK;
                     end else begin
                        st <= ST_SKIP;
                     end
                  end
               end
               ST_AACK: if (scl_fall) begin
                  sda_drv <= 1'b0;
                  cnt     <= '0;
                  if (rw) begin
                     treq <= 1'b1; ev[IRQ_DATA] <= 1'b1; st <= ST_TXW;
                  end else begin
                     first <= 1'b1; st <= ST_RXB;
                  end
               end
               ST_RXB: begin
                  if (scl_rise) begin
                     sh  <= {sh[BYTE_W-2:0], sda_s};
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall && cnt == CNT_W'(BYTE_W)) begin
                     rx_byte <= sh; rreq <= 1'b1; fbr <= first; first <= 1'b0;
                     ev[IRQ_DATA] <= 1'b1; st <= ST_RXW;
                  end
               end
               ST_RXW: if (data_rd) begin
                  rreq <= 1'b0; fbr <= 1'b0; hold <= 1'b1; sda_drv <= 1'b1; st <= ST_RXACK;
               end
               ST_RXACK: if (scl_fall) begin
                  sda_drv <= 1'b0; cnt <= '0; st <= ST_RXB;
               end
               ST_TXW: if (data_wr) begin
                  sh <= tx_byte; treq <= 1'b0; hold <= 1'b1;
                  sda_drv <= !tx_byte[BYTE_W-1]; cnt <= '0; st <= ST_TXB;
               end
               ST_TXB: if (scl_fall) begin
                  cnt <= cnt + 1'b1;
                  if (cnt == CNT_W'(BYTE_W - 1)) begin
                     sda_drv <= 1'b0; st <= ST_TXACK;
                  end else begin
                     sh <= {sh[BYTE_W-2:0], 1'b0};
                     sda_drv <= !sh[BYTE_W-2];
                  end
               end
               ST_TXACK: begin
                  if (scl_rise) ack_seen <= !sda_s;
                  else if (scl_fall) begin
                     if (ack_seen) begin
                        treq <= 1'b1; ev[IRQ_DATA] <= 1'b1; st <= ST_TXW;
                     end else begin
                        st <= ST_SKIP;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign scl_oe = rreq || treq || hold;
   assign sda_oe = sda_drv;
endmodule

// File: rtl/i2ct_irq.sv
module i2ct_irq #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] ev,
   input  logic         mask_wr,
   input  logic         clr_wr,
   input  logic [N-1:0] wbits,
   output logic [N-1:0] raw,
   output logic [N-1:0] mask,
   output logic [N-1:0] mis,
   output logic         irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw  <= '0;
         mask <= '0;
      end else begin
         if (mask_wr) mask <= wbits;
         for (int k = 0; k < N; k++) begin
            if (ev[k])                    raw[k] <= 1'b1;
            else if (clr_wr && wbits[k])  raw[k] <= 1'b0;
         end
      end
   end

   assign mis = raw & mask;
   assign irq = |mis;
endmodule

// File: rtl/i2ct_target.sv
module i2ct_target
   import i2ct_pkg::*;
#(
   parameter int ADDR_W      = 5,
   parameter int BUS_W       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [BUS_W-1:0]  reg_wdata,
   output logic [BUS_W-1:0]  reg_rdata,
   output logic              irq,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_oe,
   output logic              sda_oe
);
   localparam logic [ADDR_W-1:0] A_OWN  = ADDR_W'(OFS_OWN);
   localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFS_CTL);
   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
   localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(OFS_RAW);
   localparam logic [ADDR_W-1:0] A_MIS  = ADDR_W'(OFS_MIS);
   localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);

   generate
      if (BUS_W < BYTE_BITS) begin : g_bad_bus
         $error("i2ct_target: BUS_W narrower than a byte");
      end
      if ((1 << ADDR_W) <= OFS_CLR) begin : g_bad_addr
         $error("i2ct_target: ADDR_W cannot reach every register");
      end
   endgenerate

   logic [ADR_BITS-1:0]  own_q;
   logic                 act_q;
   logic [1:0]           line_s;
   logic [BYTE_BITS-1:0] rx_byte;
   logic                 rreq, treq, fbr;
   logic [IRQ_N-1:0]     eng_ev, irq_raw, irq_mask, irq_mis;
   logic                 unused_hi;

   wire data_rd = reg_rd && reg_addr == A_DATA;
   wire data_wr = reg_wr && reg_addr == A_DATA;
   wire mask_wr = reg_wr && reg_addr == A_MASK;
   wire clr_wr  = reg_wr && reg_addr == A_CLR;

   assign unused_hi = ^reg_wdata[BUS_W-1:BYTE_BITS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_q <= '0;
         act_q <= 1'b0;
      end else if (reg_wr) begin
         if (reg_addr == A_OWN) own_q <= reg_wdata[ADR_BITS-1:0];
         if (reg_addr == A_CTL) act_q <= reg_wdata[0];
      end
   end

   i2ct_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(line_s)
   );

   i2ct_engine #(.BYTE_W(BYTE_BITS), .ADR_W(ADR_BITS)) u_eng (
      .clk(clk), .rst_n(rst_n), .active(act_q), .own_addr(own_q),
      .scl_s(line_s[1]), .sda_s(line_s[0]),
      .data_rd(data_rd), .data_wr(data_wr), .tx_byte(reg_wdata[BYTE_BITS-1:0]),
      .rx_byte(rx_byte), .rreq(rreq), .treq(treq), .fbr(fbr), .ev(eng_ev),
      .scl_oe(scl_oe), .sda_oe(sda_oe)
   );

   i2ct_irq #(.N(IRQ_N)) u_irq (
      .clk(clk), .rst_n(rst_n), .ev(eng_ev), .mask_wr(mask_wr), .clr_wr(clr_wr),
      .wbits(reg_wdata[IRQ_N-1:0]), .raw(irq_raw), .mask(irq_mask),
      .mis(irq_mis), .irq(irq)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_OWN:  reg_rdata = BUS_W'(own_q);
         A_CTL:  reg_rdata = BUS_W'({fbr, treq, rreq});
         A_DATA: reg_rdata = BUS_W'(rx_byte);
         A_MASK: reg_rdata = BUS_W'(irq_mask);
         A_RAW:  reg_rdata = BUS_W'(irq_raw);
         A_MIS:  reg_rdata = BUS_W'(irq_mis);
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/i2ct_chk.sv
module i2ct_chk #(
   parameter int N = 3
) (
   input logic         clk,
   input logic         rst_n,
   input logic         active,
   input logic         rreq,
   input logic         treq,
   input logic         fbr,
   input logic         data_rd,
   input logic         data_wr,
   input logic [N-1:0] ev,
   input logic [N-1:0] raw,
   input logic         clr_wr,
   input logic [N-1:0] wbits,
   input logic         scl_oe,
   input logic         sda_oe
);
   // R3
   inactive_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && $past(!active)) |-> (!scl_oe && !sda_oe));

   // R4
   rreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rreq && active && !data_rd) |=> (rreq || ev[1] || ev[2]));

   // R6
   treq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (treq && active && !data_wr) |=> (treq || ev[1] || ev[2]));

   // R6
   req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rreq, treq}));

   // R5
   first_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fbr |-> rreq);

   // R9
   raw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev != '0) |=> ((raw & $past(ev)) == $past(ev)));

   // R10
   raw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr |=> ((raw & $past(wbits & ~ev)) == '0));
endmodule

bind i2ct_target i2ct_chk #(.N(i2ct_pkg::IRQ_N)) u_chk (
   .clk(clk), .rst_n(rst_n), .active(act_q), .rreq(rreq), .treq(treq), .fbr(fbr),
   .data_rd(data_rd), .data_wr(data_wr), .ev(eng_ev), .raw(irq_raw),
   .clr_wr(clr_wr), .wbits(reg_wdata[i2ct_pkg::IRQ_N-1:0]),
   .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/tb_i2ct_target.sv
`timescale 1ns/1ps
module tb_i2ct_target;
   localparam int HALF = 10;
   localparam logic [6:0] OWN = 7'h5A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq, scl_oe, sda_oe;
   logic        m_scl_low = 1'b0, m_sda_low = 1'b0;
   logic        scl_line, sda_line;

   assign scl_line = !(m_scl_low || scl_oe);
   assign sda_line = !(m_sda_low || sda_oe);

   always #10 clk = ~clk;

   i2ct_target dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
      .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
   );

   int n_chk = 0, n_fail = 0;
   logic [8:0] rx_q [$];
   logic [7:0] tx_q [$];
   logic [7:0] rd_q [$];
   bit sw_en = 0, mon_busy = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input int a, input logic [31:0] d);
      @(negedge clk); reg_addr = 5'(a); reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic bus_rd(input int a, output logic [31:0] d);
      @(negedge clk); reg_addr = 5'(a); reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk); reg_rd = 1'b0;
   endtask

   task automatic dly();
      repeat (HALF) @(negedge clk);
   endtask

   task automatic m_start();
      m_sda_low = 1'b0; dly(); m_scl_low = 1'b0; wait (scl_line); dly();
      m_sda_low = 1'b1; dly(); m_scl_low = 1'b1; dly();
   endtask

   task automatic m_stop();
      m_sda_low = 1'b1; dly(); m_scl_low = 1'b0; wait (scl_line); dly();
      m_sda_low = 1'b0; dly();
   endtask

   task automatic m_bit(input bit b, output bit r);
      m_sda_low = !b; dly(); m_scl_low = 1'b0; wait (scl_line); dly();
      r = sda_line; m_scl_low = 1'b1; dly();
   endtask

   task automatic m_byte_w(input logic [7:0] d, output bit ack);
      bit r;
      for (int i = 7; i >= 0; i--) m_bit(d[i], r);
      m_bit(1'b1, r);
      ack = !r;
   endtask

   task automatic m_byte_r(input bit ack, output logic [7:0] d);
      bit r;
      for (int i = 7; i >= 0; i--) begin m_bit(1'b1, r); d[i] = r; end
      m_bit(!ack, r);
   endtask

   // scoreboard monitor: plays software, pops expected receive bytes, supplies send bytes
   initial begin
      logic [31:0] st, d;
      logic [8:0]  e;
      forever begin
         @(negedge clk);
         if (sw_en) begin
            mon_busy = 1;
            bus_rd('h04, st);
            if (st[0]) begin
               bus_rd('h08, d);
               if (rx_q.size() == 0) chk("R8 unexpected received byte", d, 32'hx);
               else begin
                  e = rx_q.pop_front();
                  chk("R4 received byte", d[7:0], e[7:0]);
                  chk("R5 first-byte flag", st[2], e[8]);
               end
            end else if (st[1]) begin
               if (tx_q.size() == 0) begin
                  chk("R7 unexpected send request", st, 32'h0);
                  bus_wr('h08, 32'hFF);
               end else bus_wr('h08, {24'h0, tx_q.pop_front()});
            end
            mon_busy = 0;
         end
      end
   end

   task automatic sw_off();
      sw_en = 0; wait (!mon_busy); @(negedge clk);
   endtask

   task automatic push_rx(input logic [7:0] b, input bit first);
      rx_q.push_back({first, b});
   endtask

   task automatic read_chk(input bit ack, input string tag);
      logic [7:0] d;
      m_byte_r(ack, d);
      chk(tag, d, rd_q.pop_front());
   endtask

   bit bdone, back;
   task automatic poll_stat(input int bitn, output logic [31:0] st);
      for (int i = 0; i < 300; i++) begin
         bus_rd('h04, st);
         if (st[bitn]) break;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] v;
      bit ack;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      bus_rd('h00, v); chk("R1 own address", v, 0);
      bus_rd('h04, v); chk("R1 status", v, 0);
      bus_rd('h0C, v); chk("R1 mask", v, 0);
      bus_rd('h10, v); chk("R1 raw", v, 0);
      chk("R1 lines and irq", {scl_oe, sda_oe, irq}, 3'b000);

      // R11 register map
      bus_wr('h00, {25'h0, OWN});
      bus_wr('h04, 32'h1);
      bus_rd('h00, v); chk("R11 own address readback", v, {25'h0, OWN});
      bus_rd('h04, v); chk("R11 status shares control offset", v, 0);

      // R2 R4 R5 multi-byte write through scoreboard
      sw_en = 1;
      push_rx(8'hA5, 1); push_rx(8'h00, 0); push_rx(8'hFF, 0);
      m_start();
      m_byte_w({OWN, 1'b0}, ack); chk("R2 address ack", ack, 1);
      m_byte_w(8'hA5, ack); chk("R4 ack byte 1", ack, 1);
      m_byte_w(8'h00, ack); chk("R4 ack byte 2", ack, 1);
      m_byte_w(8'hFF, ack); chk("R4 ack byte 3", ack, 1);
      m_stop();
      dly();
      sw_off();
      chk("R4 all bytes consumed", rx_q.size(), 0);

      // R4 R5 R9 stretching with silent software, data interrupt
      bus_wr('h18, 32'h7);
      bus_wr('h0C, 32'h1);
      m_start();
      m_byte_w({OWN, 1'b0}, ack); chk("R2 address ack 2", ack, 1);
      bdone = 0;
      fork begin m_byte_w(8'h3C, back); bdone = 1; end join_none
      poll_stat(0, v);
      chk("R5 status first byte", v, 32'h5);
      repeat (40) @(negedge clk);
      chk("R4 clock held low", {scl_oe, scl_line}, 2'b10);
      chk("R4 master still blocked", bdone, 0);
      bus_rd('h10, v); chk("R9 data raw set", v[0], 1);
      chk("R9 irq from data", irq, 1);
      bus_rd('h08, v); chk("R4 data value", v, 32'h3C);
      wait (bdone); chk("R4 ack after read", back, 1);
      bdone = 0;
      fork begin m_byte_w(8'h81, back); bdone = 1; end join_none
      poll_stat(0, v);
      chk("R5 status later byte", v, 32'h1);
      bus_rd('h08, v); chk("R4 data value 2", v, 32'h81);
      wait (bdone);
      m_stop(); dly();
      bus_rd('h04, v); chk("R4 status after read", v, 0);
      bus_rd('h10, v); chk("R9 raw all events", v, 32'h7);
      bus_rd('h14, v); chk("R9 masked equals raw and mask", v, 32'h1);

      // R10 clear behaviour
      bus_wr('h18, 32'h0); bus_rd('h10, v); chk("R10 write zero no effect", v, 32'h7);
      bus_wr('h18, 32'h2); bus_rd('h10, v); chk("R10 clear start only", v, 32'h5);
      bus_rd('h18, v); chk("R10 clear reads zero", v, 0);
      bus_wr('h18, 32'h5); bus_rd('h10, v); chk("R10 clear rest", v, 0);
      chk("R10 irq low after clear", irq, 0);

      // R2 R9 mismatch with start interrupt only
      bus_wr('h0C, 32'h2);
      m_start(); dly();
      bus_rd('h10, v); chk("R9 start raw", v, 32'h2);
      chk("R9 irq from start", irq, 1);
      m_byte_w(8'h33 << 1, ack); chk("R2 mismatch no ack", ack, 0);
      m_byte_w(8'h55, ack); chk("R2 mismatch data no ack", ack, 0);
      bus_rd('h04, v); chk("R2 mismatch no request", v, 0);
      m_stop(); dly();
      bus_rd('h10, v); chk("R9 stop raw", v, 32'h6);
      bus_rd('h14, v); chk("R9 stop masked off", v, 32'h2);
      bus_wr('h18, 32'h7); bus_wr('h0C, 32'h0);

      // R6 R7 read transfer
      tx_q.push_back(8'hC3); tx_q.push_back(8'h17);
      rd_q.push_back(8'hC3); rd_q.push_back(8'h17);
      sw_en = 1;
      m_start();
      m_byte_w({OWN, 1'b1}, ack); chk("R6 read address ack", ack, 1);
      read_chk(1'b1, "R6 first sent byte");
      read_chk(1'b0, "R6 second sent byte");
      repeat (40) @(negedge clk);
      chk("R7 lines free after nack", {scl_oe, sda_oe}, 2'b00);
      m_stop(); dly();
      sw_off();
      chk("R6 send queue used", tx_q.size(), 0);

      // R8 abandoned partial byte, repeated START
      tx_q.push_back(8'h9E); rd_q.push_back(8'h9E);
      sw_en = 1;
      m_start();
      m_byte_w({OWN, 1'b0}, ack); chk("R8 write address ack", ack, 1);
      m_bit(1'b1, ack); m_bit(1'b0, ack); m_bit(1'b1, ack); m_bit(1'b1, ack);
      m_start();
      m_byte_w({OWN, 1'b1}, ack); chk("R8 repeated start address ack", ack, 1);
      read_chk(1'b0, "R8 byte after repeated start");
      m_stop(); dly();
      sw_off();
      bus_rd('h04, v); chk("R8 no pending request", v, 0);

      // R3 inactive device
      bus_wr('h04, 32'h0);
      bus_wr('h18, 32'h7);
      m_start();
      m_byte_w({OWN, 1'b0}, ack); chk("R3 inactive no ack", ack, 0);
      m_stop(); dly();
      bus_rd('h10, v); chk("R3 inactive no raw", v, 0);
      bus_rd('h04, v); chk("R3 inactive no status", v, 0);

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule